// File: doc/BRIEF.md
# Video DRAM Power-Up Initialization Sequencer

This controller-side block takes a multiport video DRAM from power-on to the point where normal traffic may start. While supply is not reported good, and during reset, it holds the row strobe, column strobe and transfer/output-enable lines inactive (high) and keeps the serial clock low. When power-good is sampled high, it waits out a settling pause. The pause length in clocks is worked out from a clock-frequency parameter and a pause-time parameter.

After the pause, two dummy-cycle streams start in the same clock and run side by side. The first is a train of row-strobe pulses; when the refresh-counter mode input is set, each of these pulses is instead a column-before-row refresh cycle. The second is a train of serial-clock pulses. When both trains have finished, the block raises `ready` and gives a one-cycle `mode_req` pulse, so that a follow-on step can program the memory's undefined internal state. If power-good drops at any point, the sequence is abandoned and starts again from the beginning.

Top module: `vram_pwrup_seq`

## Requirements
- R1: While `rst` is high or `pwr_good` is low, `row_n`, `col_n` and `xfer_oe_n` are high, and `ser_clk`, `busy`, `ready` and `mode_req` are low.
- R2: `busy` rises in the cycle after `pwr_good` is first sampled high. For the first PAUSE_CYC = ceil(CLK_KHZ*PAUSE_US/1000) busy cycles, no strobe moves.
- R3: With refresh-counter mode clear, the row stream is DUMMY_N pulses of `row_n` low. Each low lasts RAS_LO cycles and is followed by RAS_HI high cycles. `col_n` stays high throughout.
- R4: The serial stream is DUMMY_N pulses of `ser_clk` high, each lasting SC_HI cycles and followed by SC_LO low cycles. Its first pulse starts in the same cycle as the row stream.
- R5: With refresh-counter mode set, each row-stream cycle takes `col_n` low CBR_LEAD cycles before `row_n` falls. `col_n` then stays low for the whole RAS_LO cycles of `row_n` low, and both lines rise together. There are DUMMY_N such cycles, and `row_n` never falls in the same cycle as `col_n`.
- R6: `xfer_oe_n` stays high for the whole sequence, including every dummy cycle.
- R7: `busy` stays high until the cycle after the longer stream ends; in that cycle `busy` falls and `ready` rises. Total busy cycles are PAUSE_CYC + max(row length, serial length) + 1. `ready` stays high, with all strobes idle, for as long as power remains good.
- R8: `mode_req` is high for exactly one cycle, the first cycle in which `ready` is high.
- R9: When `pwr_good` is sampled low, all outputs are at their R1 values from the next cycle on. When power returns, the block starts again with a full pause.
- R10: The refresh-counter mode is captured when the pause ends. Changes to `cbr_mode` during the dummy cycles have no effect on the stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply reported good; low aborts and restarts the sequence |
| cbr_mode | input | 1 | 1 selects column-before-row dummy cycles |
| row_n | output | 1 | Row strobe, active low |
| col_n | output | 1 | Column strobe, active low |
| xfer_oe_n | output | 1 | Transfer/output-enable, held high |
| ser_clk | output | 1 | Serial clock, idles low |
| busy | output | 1 | High during pause and dummy cycles |
| ready | output | 1 | Initialization complete |
| mode_req | output | 1 | One-cycle request for the mode-setting step |

## Verification
A wrong sequencer state shows up directly at the ports. A pause counter that is off by one moves the first strobe edge and changes the total busy count by exactly that many cycles. A miscounted train gives the wrong number of row, column or serial edges before `ready`. A lost mode latch makes the column strobe fall at the wrong point relative to the row strobe. A failure to return to idle leaves a strobe active, or `ready` high, in the first cycle after power-good is sampled low. Every one of these faults is visible within one dummy-sequence length of the event that causes it.

// File: rtl/vram_pwrup_pkg.sv
package vram_pwrup_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PAUSE = 2'd1,
        ST_DUMMY = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_LEAD = 2'd0,
        PH_ACT  = 2'd1,
        PH_REST = 2'd2,
        PH_END  = 2'd3
    } phase_t;

    // view of one pulse train
    typedef struct packed {
        logic lead;
        logic act;
        logic mode;
        logic done;
    } train_t;

    // line bundle towards the memory
    typedef struct packed {
        logic row_n;
        logic col_n;
        logic xfer_n;
        logic sclk;
    } strobes_t;

    // settling pause in clocks, rounded up so the time is never short
    function automatic int pause_cycles(input int clk_khz, input int pause_us);
        return (clk_khz * pause_us + 999) / 1000;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pwrup_pause_timer.sv
module pwrup_pause_timer #(
    parameter int CYC = 40000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt != CW'(CYC - 1))
            cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == CW'(CYC - 1));

endmodule

// File: rtl/pwrup_pulse_train.sv
module pwrup_pulse_train
    import vram_pwrup_pkg::*;
#(
    parameter int N      = 8,
    parameter int LEAD_W = 1,
    parameter int ACT_W  = 4,
    parameter int REST_W = 4
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   run,
    input  logic   lead_en,
    output train_t tr
);
    localparam int WMAX = max3(LEAD_W, ACT_W, REST_W);
    localparam int TW   = $clog2(WMAX + 1);
    localparam int CW   = $clog2(N + 1);

    phase_t        ph;
    logic [TW-1:0] tick;
    logic [CW-1:0] cnt;
    logic          mode_q;
    logic [TW-1:0] width;

    always_comb begin
        case (ph)
            PH_LEAD: width = TW'(LEAD_W - 1);
            PH_ACT:  width = TW'(ACT_W - 1);
            default: width = TW'(REST_W - 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            mode_q <= lead_en;
            ph     <= lead_en ? PH_LEAD : PH_ACT;
            tick   <= '0;
            cnt    <= '0;
        end else if (ph != PH_END) begin
            if (tick == width) begin
                tick <= '0;
                case (ph)
                    PH_LEAD: ph <= PH_ACT;
                    PH_ACT:  ph <= PH_REST;
                    default: begin
                        cnt <= cnt + 1'b1;
                        if (cnt == CW'(N - 1))
                            ph <= PH_END;
                        else
                            ph <= mode_q ? PH_LEAD : PH_ACT;
                    end
                endcase
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    assign tr.lead = run && (ph == PH_LEAD);
    assign tr.act  = run && (ph == PH_ACT);
    assign tr.mode = mode_q;
    assign tr.done = run && (ph == PH_END);

endmodule

// File: rtl/vram_pwrup_seq.sv
module vram_pwrup_seq
    import vram_pwrup_pkg::*;
#(
    parameter int CLK_KHZ  = 200000,
    parameter int PAUSE_US = 200,
    parameter int DUMMY_N  = 8,
    parameter int RAS_LO   = 6,
    parameter int RAS_HI   = 4,
    parameter int CBR_LEAD = 2,
    parameter int SC_HI    = 2,
    parameter int SC_LO    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_good,
    input  logic cbr_mode,
    output logic row_n,
    output logic col_n,
    output logic xfer_oe_n,
    output logic ser_clk,
    output logic busy,
    output logic ready,
    output logic mode_req
);
    localparam int PAUSE_CYC = pause_cycles(CLK_KHZ, PAUSE_US);

    seq_state_t st, st_nx;
    logic       pause_done;
    logic       req_sent;
    train_t     row_t, ser_t;
    strobes_t   drv;

    pwrup_pause_timer #(.CYC(PAUSE_CYC)) i_pause (
        .clk     (clk),
        .rst     (rst),
        .run     (st == ST_PAUSE),
        .expired (pause_done)
    );

    pwrup_pulse_train #(
        .N(DUMMY_N), .LEAD_W(CBR_LEAD), .ACT_W(RAS_LO), .REST_W(RAS_HI)
    ) i_row (
        .clk     (clk),
        .rst     (rst),
        .run     (st == ST_DUMMY),
        .lead_en (cbr_mode),
        .tr      (row_t)
    );

    pwrup_pulse_train #(
        .N(DUMMY_N), .LEAD_W(1), .ACT_W(SC_HI), .REST_W(SC_LO)
    ) i_ser (
        .clk     (clk),
        .rst     (rst),
        .run     (st == ST_DUMMY),
        .lead_en (1'b0),
        .tr      (ser_t)
    );

    always_comb begin
        st_nx = st;
        case (st)
            ST_IDLE:  st_nx = ST_PAUSE;
            ST_PAUSE: if (pause_done) st_nx = ST_DUMMY;
            ST_DUMMY: if (row_t.done && ser_t.done) st_nx = ST_DONE;
            default:  st_nx = ST_DONE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !pwr_good) begin
            st       <= ST_IDLE;
            req_sent <= 1'b0;
        end else begin
            st       <= st_nx;
            req_sent <= (st == ST_DONE);
        end
    end

    always_comb begin
        drv.row_n  = ~row_t.act;
        drv.col_n  = ~(row_t.lead || (row_t.act && row_t.mode));
        drv.xfer_n = 1'b1;
        drv.sclk   = ser_t.act & ~(ser_t.lead | ser_t.mode);
    end

    assign row_n     = drv.row_n;
    assign col_n     = drv.col_n;
    assign xfer_oe_n = drv.xfer_n;
    assign ser_clk   = drv.sclk;
    assign busy      = (st == ST_PAUSE) || (st == ST_DUMMY);
    assign ready     = (st == ST_DONE);
    assign mode_req  = (st == ST_DONE) && !req_sent;

endmodule

// File: rtl/vram_pwrup_chk.sv
module vram_pwrup_chk (
    input logic clk,
    input logic rst,
    input logic pwr_good,
    input logic row_n,
    input logic col_n,
    input logic ser_clk,
    input logic busy,
    input logic ready,
    input logic mode_req
);
    AST_IDLE_ON_LOSS: assert property (@(posedge clk) disable iff (rst)
        !pwr_good |=> (row_n && col_n && !ser_clk && !busy && !ready && !mode_req)); // R9

    AST_QUIET_WHEN_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (row_n && col_n && !ser_clk)); // R1

    AST_BUSY_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(busy && ready)); // R7

    AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ready && pwr_good) |=> ready); // R7

    AST_REQ_ON_READY_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> mode_req); // R8

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mode_req |=> !mode_req); // R8

    AST_COL_NOT_WITH_ROW: assert property (@(posedge clk) disable iff (rst)
        $fell(row_n) |-> !$fell(col_n)); // R5

endmodule

bind vram_pwrup_seq vram_pwrup_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .pwr_good (pwr_good),
    .row_n    (row_n),
    .col_n    (col_n),
    .ser_clk  (ser_clk),
    .busy     (busy),
    .ready    (ready),
    .mode_req (mode_req)
);

// File: tb/test_vram_pwrup_seq.sv
`timescale 1ns/1ps
module test_vram_pwrup_seq;
    localparam int CLK_KHZ = 200000;
    localparam int PUS     = 1;
    localparam int N       = 8;
    localparam int LO      = 4;
    localparam int HI      = 3;
    localparam int LEAD    = 2;
    localparam int SH      = 2;
    localparam int SL      = 3;
    localparam int P       = (CLK_KHZ * PUS + 999) / 1000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_good = 1'b0;
    logic cbr_mode = 1'b0;
    logic row_n, col_n, xfer_oe_n, ser_clk, busy, ready, mode_req;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    vram_pwrup_seq #(
        .CLK_KHZ(CLK_KHZ), .PAUSE_US(PUS), .DUMMY_N(N), .RAS_LO(LO),
        .RAS_HI(HI), .CBR_LEAD(LEAD), .SC_HI(SH), .SC_LO(SL)
    ) i_vram_pwrup_seq (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .cbr_mode(cbr_mode),
        .row_n(row_n), .col_n(col_n), .xfer_oe_n(xfer_oe_n), .ser_clk(ser_clk),
        .busy(busy), .ready(ready), .mode_req(mode_req)
    );

    function automatic int row_len(input bit cbr);
        return N * ((cbr ? LEAD : 0) + LO + HI);
    endfunction
    function automatic int ser_len();
        return N * (SH + SL);
    endfunction
    function automatic int busy_len(input bit cbr);
        int r, s;
        r = row_len(cbr);
        s = ser_len();
        return P + ((r > s) ? r : s) + 1;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // port monitor
    int  busy_cnt, row_falls, col_falls, ser_rises, row_low, col_low, ser_high;
    int  first_row, first_col, first_ser, order_bad, xfer_bad, req_cnt, req_bad, idle_bad;
    bit  exp_cbr;
    logic p_row, p_col, p_ser;

    task automatic clear_mon(input bit cbr);
        busy_cnt = 0; row_falls = 0; col_falls = 0; ser_rises = 0;
        row_low = 0; col_low = 0; ser_high = 0;
        first_row = -1; first_col = -1; first_ser = -1;
        order_bad = 0; xfer_bad = 0; req_cnt = 0; req_bad = 0; idle_bad = 0;
        exp_cbr = cbr;
        p_row = 1'b1; p_col = 1'b1; p_ser = 1'b0;
    endtask

    always @(negedge clk) begin
        if (busy) busy_cnt++;
        if (!row_n) row_low++;
        if (!col_n) col_low++;
        if (ser_clk) ser_high++;
        if (!row_n && p_row) begin
            row_falls++;
            if (first_row < 0) first_row = busy_cnt - 1;
            if (col_n != !exp_cbr) order_bad++;
        end
        if (!col_n && p_col) begin
            col_falls++;
            if (first_col < 0) first_col = busy_cnt - 1;
        end
        if (ser_clk && !p_ser) begin
            ser_rises++;
            if (first_ser < 0) first_ser = busy_cnt - 1;
        end
        if (!xfer_oe_n) xfer_bad++;
        if (mode_req) begin
            req_cnt++;
            if (!ready) req_bad++;
        end
        if (ready && (!row_n || !col_n || ser_clk || busy)) idle_bad++;
        p_row = row_n; p_col = col_n; p_ser = ser_clk;
    end

    task automatic chk_idle(input string req);
        chk(req, {row_n, col_n, xfer_oe_n, ser_clk, busy, ready, mode_req}, 7'b1110000);
    endtask

    task automatic run_full(input bit cbr, input bit toggle);
        int k;
        @(negedge clk);
        clear_mon(cbr);
        cbr_mode = cbr;
        pwr_good = 1'b1;
        k = 0;
        while (!ready && k < 2000) begin
            @(negedge clk);
            k++;
            if (toggle && k == P + 10) cbr_mode = !cbr;
        end
        chk("R7 ready reached", ready, 1);
        repeat (4) @(negedge clk);
        chk("R7 ready held", ready, 1);
        chk("R7 busy cycles", busy_cnt, busy_len(cbr));
        chk("R2 first serial edge", first_ser, P);
        chk("R2 first row edge", first_row, P + (cbr ? LEAD : 0));
        chk("R3 row pulses", row_falls, N);
        chk("R3 row low cycles", row_low, N * LO);
        chk("R5 col pulses", col_falls, cbr ? N : 0);
        chk("R5 col low cycles", col_low, cbr ? N * (LEAD + LO) : 0);
        chk("R5 col first edge", first_col, cbr ? P : -1);
        chk("R5 col/row order", order_bad, 0);
        chk("R4 serial pulses", ser_rises, N);
        chk("R4 serial high cycles", ser_high, N * SH);
        chk("R6 xfer held high", xfer_bad, 0);
        chk("R7 idle strobes after ready", idle_bad, 0);
        chk("R8 request count", req_cnt, 1);
        chk("R8 request with ready", req_bad, 0);
        if (toggle) chk("R10 mode change ignored", order_bad, 0);
        pwr_good = 1'b0;
        @(negedge clk);
        chk_idle("R9 idle after power loss");
    endtask

    task automatic run_drop(input bit cbr, input int at);
        @(negedge clk);
        clear_mon(cbr);
        cbr_mode = cbr;
        pwr_good = 1'b1;
        repeat (at) @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        chk_idle("R9 abort mid-sequence");
        repeat (3) @(negedge clk);
        chk_idle("R1 idle while power low");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        pwr_good = 1'b1;
        repeat (3) @(negedge clk);
        chk_idle("R1 reset with power good");
        rst = 1'b0;
        pwr_good = 1'b0;
        repeat (3) @(negedge clk);
        chk_idle("R1 power not good");

        run_full(1'b0, 1'b0);
        run_full(1'b1, 1'b0);
        run_full(1'b0, 1'b1);
        run_full(1'b1, 1'b1);
        run_drop(1'b0, 1);
        run_drop(1'b1, P + 3);
        run_full(1'b1, 1'b0);

        for (int i = 0; i < 4; i++) begin
            int at;
            bit c;
            c  = 1'($urandom % 2);
            at = 1 + int'($urandom % (P + 70));
            run_drop(c, at);
            run_full(1'($urandom % 2), 1'($urandom % 2));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule